// File: doc/BRIEF.md
# Serial Flash Programming Command Interface

This block is the serial front end of an in-system programming path. An external programmer drives a serial clock (`sck`) and a data input (`mosi`). The block answers on `miso`. It does this only while the programming-enable level, which is the chip's reset line held high, stays asserted. All three serial wires are sampled on the fast system clock `clk`, so `sck` must run well below `clk`.

Each instruction opens with a command byte. The command byte selects one of four transfers: a single-byte write, a single-byte read, a 256-byte page write or a 256-byte page read. The block turns each transfer into one-cycle write or read strobes on a memory-side port. It returns the bytes it reads on `miso`.

While the memory signals that a write is still in progress, the block raises `wip`. During that window, a read of the address written last returns the written byte with its top bit inverted, so a programmer can poll until the write completes.

Top module: `spi_flash_prog_if`

## Requirements
- R1: While `prog_en` is low the block issues no `mem_we` or `mem_re` strobe, whatever toggles on `sck` and `mosi`.
- R2: Bytes move most significant bit first. `mosi` is taken on `sck` rising edges, and `miso` changes only while `sck` is low, after a falling edge.
- R3: Byte write is the sequence 0x40, address-high, address-low, data. It gives exactly one `mem_we` with `mem_addr` = {address-high[ADDR_W-9:0], address-low} and `mem_wdata` = data.
- R4: Byte read is the sequence 0x20, address-high, address-low, then one further byte. It gives one `mem_re`, and the stored byte at that address appears on `miso` during the fourth byte.
- R5: Page write is 0x50, then address-high, then 256 data bytes. Byte k is written to {address-high, k}, with k running from 0 up to 255 in order, one `mem_we` per byte.
- R6: Page read is 0x30, then address-high, then 256 bytes. During these bytes `miso` returns the contents of offsets 0 to 255 of that page, in order.
- R7: After the 256th data byte of a page transfer, the next byte is decoded as a fresh command.
- R8: While `mem_busy` is high, a read of the address written last returns that written byte with bit 7 inverted. Once `mem_busy` has fallen, the true byte is returned.
- R9: A command byte other than 0x40, 0x20, 0x50 or 0x30 frames a 4-byte instruction that produces no strobe. The byte after it is decoded as a command.
- R10: Pulling `prog_en` low in the middle of an instruction discards it. The next byte after `prog_en` returns high is decoded as a command.
- R11: `wip` is high from the `mem_we` strobe until `mem_busy` falls, and is low otherwise.
- R12: `mem_we` and `mem_re` are never high together, and each is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming enable (reset line held high) |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| mem_addr | output | ADDR_W | Memory address for the current strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe; data expected on `mem_rdata` one clock later |
| mem_rdata | input | 8 | Read data from memory |
| mem_busy | input | 1 | Memory write still in progress |
| wip | output | 1 | Write-in-progress status |

## Verification
Directed sequences come first: a byte write followed at once by a read of the same address, to tell a polled value from true data. Then a read of an untouched location, an unknown command, an instruction cut short by `prog_en`, and a full page written then read back. Each of these is followed by an ordinary instruction, which shows whether byte framing stayed aligned. Random byte writes and reads over a 1 KiB window are then checked against a shadow copy kept by the bench. This tells address assembly errors apart from data bit-order errors.

// File: rtl/spi_flash_prog_if.sv
module spi_flash_prog_if #(
  parameter int ADDR_W = 13,
  parameter logic [7:0] CMD_BW = 8'h40,
  parameter logic [7:0] CMD_BR = 8'h20,
  parameter logic [7:0] CMD_PW = 8'h50,
  parameter logic [7:0] CMD_PR = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_busy,
  output logic              wip
);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [2:0] {PH_CMD, PH_AHI, PH_ALO, PH_DATA, PH_SKIP} phase_t;

  phase_t ph;
  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [7:0] rx, tx, cmd, ahi, off;
  logic [1:0] skip_n, rd_pipe;
  logic [ADDR_W-1:0] lw_addr;
  logic lw7, lw_valid;

  wire rise = sck_q[1] & ~sck_q[2];
  wire fall = ~sck_q[1] & sck_q[2];
  wire [7:0] rx_next = {rx[6:0], mosi_q[1]};
  wire byte_done = rise && (bit_cnt == 3'd7);
  wire known = (rx_next == CMD_BW) || (rx_next == CMD_BR) ||
               (rx_next == CMD_PW) || (rx_next == CMD_PR);
  wire is_wr = (cmd == CMD_BW) || (cmd == CMD_PW);
  wire is_pg = (cmd == CMD_PW) || (cmd == CMD_PR);
  wire poll  = mem_busy && lw_valid && (mem_addr == lw_addr);

  assign wip = mem_busy | mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_CMD;
      sck_q <= '0;
      mosi_q <= '0;
      bit_cnt <= '0;
      rx <= '0;
      tx <= '0;
      cmd <= '0;
      ahi <= '0;
      off <= '0;
      skip_n <= '0;
      rd_pipe <= '0;
      lw_addr <= '0;
      lw7 <= 1'b0;
      lw_valid <= 1'b0;
      miso <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      rd_pipe <= {rd_pipe[0], 1'b0};
      if (!prog_en) begin
        ph <= PH_CMD;
        bit_cnt <= '0;
        rx <= '0;
        tx <= '0;
        miso <= 1'b0;
        rd_pipe <= '0;
      end else begin
        if (rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx <= rx_next;
        end
        if (fall) begin
          miso <= tx[7];
          tx <= {tx[6:0], 1'b0};
        end
        if (rd_pipe[1])
          tx <= poll ? {~lw7, mem_rdata[6:0]} : mem_rdata;
        if (byte_done) begin
          case (ph)
            PH_CMD: begin
              cmd <= rx_next;
              skip_n <= '0;
              ph <= known ? PH_AHI : PH_SKIP;
            end
            PH_AHI: begin
              ahi <= rx_next;
              off <= '0;
              if (is_pg) begin
                ph <= PH_DATA;
                if (!is_wr) begin
                  mem_addr <= {rx_next[HI_W-1:0], 8'h00};
                  mem_re <= 1'b1;
                  rd_pipe[0] <= 1'b1;
                end
              end else begin
                ph <= PH_ALO;
              end
            end
            PH_ALO: begin
              off <= rx_next;
              ph <= PH_DATA;
              if (!is_wr) begin
                mem_addr <= {ahi[HI_W-1:0], rx_next};
                mem_re <= 1'b1;
                rd_pipe[0] <= 1'b1;
              end
            end
            PH_DATA: begin
              if (is_wr) begin
                mem_we <= 1'b1;
                mem_addr <= {ahi[HI_W-1:0], off};
                mem_wdata <= rx_next;
                lw_addr <= {ahi[HI_W-1:0], off};
                lw7 <= rx_next[7];
                lw_valid <= 1'b1;
              end
              if (is_pg && off != 8'hFF) begin
                off <= off + 8'd1;
                if (!is_wr) begin
                  mem_addr <= {ahi[HI_W-1:0], off + 8'd1};
                  mem_re <= 1'b1;
                  rd_pipe[0] <= 1'b1;
                end
              end else begin
                ph <= PH_CMD;
              end
            end
            default: begin
              skip_n <= skip_n + 2'd1;
              if (skip_n == 2'd2) ph <= PH_CMD;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_prog_if_chk.sv
module spi_flash_prog_if_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_en,
  input logic sck,
  input logic miso,
  input logic mem_we,
  input logic mem_re
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R12
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R12
  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re); // R12
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_en && !$past(prog_en)) |-> (!mem_we && !mem_re)); // R1
  AST_MISO_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> !sck); // R2
endmodule

bind spi_flash_prog_if spi_flash_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck),
  .miso(miso), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/sim_spi_flash_prog_if.sv
module sim_spi_flash_prog_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int BUSY_CYC = 600;
  localparam int MAX_CYC = 190000;

  logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, mem_we, mem_re, wip;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_prog_if u0 (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
    .miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_busy(mem_busy), .wip(wip)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  logic [7:0] mdl [1024];
  logic [7:0] shadow [1024];
  int busy_cnt = 0;
  int we_n = 0, re_n = 0;
  logic [12:0] log_a [512];
  logic [7:0] log_d [512];
  assign mem_busy = (busy_cnt != 0);

  initial for (int i = 0; i < 1024; i++) begin
    mdl[i] = init_val(i);
    shadow[i] = init_val(i);
  end

  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (mem_re) begin
      mem_rdata <= mdl[mem_addr[9:0]];
      re_n <= re_n + 1;
    end
    if (mem_we) begin
      mdl[mem_addr[9:0]] <= mem_wdata;
      busy_cnt <= BUSY_CYC;
      log_a[we_n % 512] <= mem_addr;
      log_d[we_n % 512] <= mem_wdata;
      we_n <= we_n + 1;
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = o[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic bw(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(8'h40, r); xfer({3'b0, a[12:8]}, r); xfer(a[7:0], r); xfer(d, r);
    repeat (4) @(negedge clk);
    shadow[a[9:0]] = d;
  endtask

  task automatic br(input logic [12:0] a, output logic [7:0] d);
    logic [7:0] r;
    xfer(8'h20, r); xfer({3'b0, a[12:8]}, r); xfer(a[7:0], r); xfer(8'h00, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (mem_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    int base;
    void'($urandom(32'h1D5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(miso == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0 && wip == 1'b0,
          "R1 reset state", {miso, mem_we, mem_re, wip}, 0);

    xfer(8'h40, r); xfer(8'h01, r); xfer(8'h23, r); xfer(8'hA5, r);
    repeat (4) @(negedge clk);
    check(we_n == 0 && re_n == 0, "R1 disabled", we_n + re_n, 0);

    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    bw(13'h0123, 8'hA5);
    check(we_n == 1, "R3 write count", we_n, 1);
    check(log_a[0] == 13'h0123 && log_d[0] == 8'hA5, "R3 R2 write addr/data",
          {log_a[0], log_d[0]}, {13'h0123, 8'hA5});
    check(wip == 1'b1, "R11 wip during write", wip, 1);
    br(13'h0123, r);
    check(r == 8'h25, "R8 polled read", r, 8'h25);
    wait_idle();
    check(wip == 1'b0, "R11 wip after write", wip, 0);
    br(13'h0123, r);
    check(r == 8'hA5, "R8 R4 true data after write", r, 8'hA5);
    br(13'h02F0, r);
    check(r == shadow[10'h2F0], "R4 untouched read", r, shadow[10'h2F0]);

    base = we_n;
    xfer(8'h99, r); xfer(8'h40, r); xfer(8'h00, r); xfer(8'h11, r);
    repeat (4) @(negedge clk);
    check(we_n == base, "R9 unknown command no write", we_n, base);
    bw(13'h0010, 8'h6E);
    check(we_n == base + 1 && log_a[base % 512] == 13'h0010 && log_d[base % 512] == 8'h6E,
          "R9 resync after unknown", {log_a[base % 512], log_d[base % 512]}, {13'h0010, 8'h6E});
    wait_idle();

    base = we_n;
    xfer(8'h40, r); xfer(8'h01, r);
    prog_en = 1'b0;
    repeat (5) @(negedge clk);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    bw(13'h0200, 8'h3C);
    check(we_n == base + 1 && log_a[base % 512] == 13'h0200 && log_d[base % 512] == 8'h3C,
          "R10 abort and restart", {log_a[base % 512], log_d[base % 512]}, {13'h0200, 8'h3C});
    wait_idle();

    base = we_n;
    xfer(8'h50, r); xfer(8'h02, r);
    for (int k = 0; k < 256; k++) begin
      xfer(8'(k ^ 8'h5A), r);
      shadow[10'h200 + k] = 8'(k ^ 8'h5A);
    end
    repeat (4) @(negedge clk);
    check(we_n == base + 256, "R5 page write count", we_n - base, 256);
    begin
      int errs = 0;
      for (int k = 0; k < 256; k++)
        if (log_a[(base + k) % 512] != 13'(12'h200 + k) || log_d[(base + k) % 512] != 8'(k ^ 8'h5A))
          errs++;
      check(errs == 0, "R5 page write order", errs, 0);
    end
    bw(13'h0005, 8'hC3);
    check(log_a[(base + 256) % 512] == 13'h0005 && log_d[(base + 256) % 512] == 8'hC3,
          "R7 command after page write", log_d[(base + 256) % 512], 8'hC3);
    wait_idle();

    xfer(8'h30, r); xfer(8'h02, r);
    begin
      int errs = 0;
      for (int k = 0; k < 256; k++) begin
        xfer(8'h00, r);
        if (r != shadow[10'h200 + k]) errs++;
      end
      check(errs == 0, "R6 page read data", errs, 0);
    end
    br(13'h0005, r);
    check(r == 8'hC3, "R7 command after page read", r, 8'hC3);

    for (int n = 0; n < 40; n++) begin
      logic [12:0] a;
      logic [7:0] d;
      a = 13'($urandom_range(0, 1023));
      if ($urandom_range(0, 1) == 1) begin
        d = 8'($urandom);
        base = we_n;
        bw(a, d);
        check(we_n == base + 1 && log_a[base % 512] == a && log_d[base % 512] == d,
              "R3 random write", {log_a[base % 512], log_d[base % 512]}, {a, d});
        wait_idle();
      end else begin
        br(a, d);
        check(d == shadow[a[9:0]], "R4 random read", d, shadow[a[9:0]]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", MAX_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule